// File: doc/BRIEF.md
# Row-select switch channel sequencer

This block picks one of 64 row channels at a time and drives two logic-level output ports, A and B, for every channel. A channel counter moves to the next channel on each rising edge of an external step input. Only the selected channel may show an active port. Every other port sits at its inactive level. The A and B states of the selected channel come from one of two sources: two direct input pins, or a 16-step program that is played out once per channel visit. Each port has its own polarity, so a port can be active high or active low.

Settings are shifted in serially and take effect only when a load strobe arrives. The serial output of the shift register can feed the next device, so several devices can be configured from one serial line. A device can also be told to wait in a parked state. It leaves that state on a carry pulse from the previous device. When it passes its final channel, it raises its own carry pulse and returns to the parked state. In this way a row of devices selects channels one after another.

The control is a two-state machine. ST_SEL means a channel is selected and ST_PARK means no channel is selected. Reset enters ST_PARK when the park bit is set and ST_SEL otherwise, with the start channel loaded in both cases. In ST_SEL, a step edge on a channel other than the final one advances the counter (SEL to SEL, advance). A step edge on the final channel sends a carry pulse and loads the start channel. The machine then stays in ST_SEL when the park bit is clear (SEL to SEL, wrap) or moves to ST_PARK when it is set (SEL to PARK, wrap). In ST_PARK, a carry-in pulse selects the start channel (PARK to SEL, resume).

Top module: `rowsw_seq`

## Requirements
- R1: After reset with the all-zero power-up settings (direct mode, both ports active low, ascending order, no park, start channel 0), channel 0 is selected, sel_valid_o is 1 and carry_o is 0. With both direct pins low, every port output is high.
- R2: In ST_SEL, each rising edge of step_i moves the selection by one channel: up when the order bit is 0, down when it is 1. A step_i held high gives no further moves.
- R3: Every port of a channel that is not selected is at its inactive level. The inactive level is low when the port's polarity bit is 1 (active high) and high when it is 0 (active low). At most one channel shows an active A port.
- R4: In direct mode (mode bit 0), the selected channel's A and B ports are active exactly when dir_a_i and dir_b_i are 1, mapped through the port polarity.
- R5: In sequencer mode (mode bit 1), the selected channel's ports follow the program step: bit 0 of a step is A and bit 1 is B. The step is 0 in the first cycle of a channel visit, advances by one each clock, and holds at step 15.
- R6: A step edge on the final channel (63 ascending, 0 descending) raises carry_o for exactly one cycle and loads the start channel. If the park bit is 1, no channel is selected afterwards (sel_valid_o 0).
- R7: While parked, step_i is ignored and all ports are inactive. A cycle with carry_i 1 selects the start channel at program step 0. carry_i has no effect while a channel is selected.
- R8: Each clock with cfg_shift_i 1 shifts cfg_sdi_i into the 43-bit configuration register. cfg_sdo_o shows the bit about to leave, so the first bit shifted in appears on cfg_sdo_o after 43 shifts, followed by the later bits in order. Word layout: bit 0 mode, bit 1 polarity A, bit 2 polarity B, bit 3 order, bit 4 park, bits 10:5 start channel, bits 11+2k and 12+2k for step k A and B.
- R9: Shifting alone does not change the outputs. A cycle with cfg_load_i 1 applies the shifted word from the next cycle on. A step edge in the same cycle as a load still uses the old order.
- R10: The synchronous reset selects the start channel (or parks, if the park bit is set), clears the program step and keeps the loaded settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also paces the program steps |
| rst | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | Step input; each rising edge advances the channel |
| carry_i | input | 1 | Carry from the previous device; leaves the parked state |
| dir_a_i | input | 1 | Direct active state for port A |
| dir_b_i | input | 1 | Direct active state for port B |
| cfg_shift_i | input | 1 | Shift enable for the configuration register |
| cfg_sdi_i | input | 1 | Serial configuration data in |
| cfg_load_i | input | 1 | Load strobe that applies the shifted settings |
| cfg_sdo_o | output | 1 | Serial configuration data out, for the next device |
| carry_o | output | 1 | One-cycle pulse on a wrap past the final channel |
| sel_valid_o | output | 1 | A channel is selected |
| sel_chan_o | output | 6 | Index of the selected channel |
| port_a_o | output | 64 | Port A level of every channel |
| port_b_o | output | 64 | Port B level of every channel |

## Verification
A settings load and a step edge can fall in the same cycle. The bench shifts in a word that reverses the counting order, then raises cfg_load_i and step_i together. It then checks that the channel moved in the old direction and that the following step moves in the new one. A step edge on the final channel is also checked in the same cycle as its wrap. Carry, reload of the start channel and, where the park bit is set, the drop of selection all have to appear together one cycle later.

// File: rtl/rowsw_pkg.sv
package rowsw_pkg;
    localparam int NUM_CH    = 64;
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int SEQ_STEPS = 16;
    localparam int SEQ_W     = $clog2(SEQ_STEPS);

    // Packed layout: the last field sits at bit 0.
    typedef struct packed {
        logic [SEQ_STEPS-1:0][1:0] prog;   // step k: bit0 = A, bit1 = B
        logic [CH_W-1:0]           start;
        logic                      park;
        logic                      desc;
        logic                      pol_b;  // 1 = active high
        logic                      pol_a;
        logic                      seq_mode;
    } rowsw_cfg_t;

    localparam int CFG_W = $bits(rowsw_cfg_t);

    typedef enum logic {
        ST_PARK = 1'b0,
        ST_SEL  = 1'b1
    } rowsw_state_t;
endpackage

// File: rtl/rowsw_cfg_chain.sv
module rowsw_cfg_chain
    import rowsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       shift_i,
    input  logic       sdi_i,
    input  logic       load_i,
    output logic       sdo_o,
    output rowsw_cfg_t cfg_o
);
    logic [CFG_W-1:0] shreg_q;
    rowsw_cfg_t       live_q = '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
        end else if (shift_i) begin
            shreg_q <= {sdi_i, shreg_q[CFG_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (load_i) begin
            live_q <= rowsw_cfg_t'(shreg_q);
        end
    end

    assign sdo_o = shreg_q[0];
    assign cfg_o = live_q;

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(cfg_o));
endmodule

// File: rtl/rowsw_chan_fsm.sv
module rowsw_chan_fsm
    import rowsw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  rowsw_cfg_t       cfg_i,
    input  logic             step_i,
    input  logic             carry_i,
    output logic             sel_valid_o,
    output logic [CH_W-1:0]  chan_o,
    output logic [SEQ_W-1:0] step_idx_o,
    output logic             carry_o
);
    rowsw_state_t     st_q, st_d;
    logic [CH_W-1:0]  ch_q, ch_d;
    logic [SEQ_W-1:0] idx_q, idx_d;
    logic             carry_q, carry_d;
    logic             step_q;
    logic             step_rise;
    logic [CH_W-1:0]  final_ch;

    assign step_rise = step_i & ~step_q;
    assign final_ch  = cfg_i.desc ? '0 : CH_W'(NUM_CH - 1);

    always_ff @(posedge clk) begin
        step_q <= step_i;
        if (rst) begin
            st_q    <= cfg_i.park ? ST_PARK : ST_SEL;
            ch_q    <= cfg_i.start;
            idx_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            ch_q    <= ch_d;
            idx_q   <= idx_d;
            carry_q <= carry_d;
        end
    end

    always_comb begin
        st_d    = st_q;
        ch_d    = ch_q;
        carry_d = 1'b0;
        idx_d   = (idx_q == SEQ_W'(SEQ_STEPS - 1)) ? idx_q : idx_q + 1'b1;
        unique case (st_q)
            ST_SEL: begin
                if (step_rise) begin
                    idx_d = '0;
                    if (ch_q == final_ch) begin
                        carry_d = 1'b1;
                        ch_d    = cfg_i.start;
                        if (cfg_i.park) st_d = ST_PARK;
                    end else if (cfg_i.desc) begin
                        ch_d = ch_q - 1'b1;
                    end else begin
                        ch_d = ch_q + 1'b1;
                    end
                end
            end
            ST_PARK: begin
                idx_d = '0;
                if (carry_i) begin
                    st_d = ST_SEL;
                    ch_d = cfg_i.start;
                end
            end
            default: st_d = ST_PARK;
        endcase
    end

    assign sel_valid_o = (st_q == ST_SEL);
    assign chan_o      = ch_q;
    assign step_idx_o  = idx_q;
    assign carry_o     = carry_q;

    assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
        (sel_valid_o && step_rise && !cfg_i.desc && chan_o != CH_W'(NUM_CH - 1))
        |=> chan_o == $past(chan_o) + 1'b1);

    assert_no_move_R2: assert property (@(posedge clk) disable iff (rst)
        (!step_rise && !(!sel_valid_o && carry_i)) |=> $stable(chan_o));

    assert_carry_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        carry_o |=> !carry_o);

    assert_resume_R7: assert property (@(posedge clk) disable iff (rst)
        (!sel_valid_o && carry_i)
        |=> (sel_valid_o && chan_o == $past(cfg_i.start) && step_idx_o == '0));
endmodule

// File: rtl/rowsw_port_drive.sv
module rowsw_port_drive
    import rowsw_pkg::*;
(
    input  rowsw_cfg_t        cfg_i,
    input  logic              sel_valid_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic [SEQ_W-1:0]  step_idx_i,
    input  logic              dir_a_i,
    input  logic              dir_b_i,
    output logic [NUM_CH-1:0] port_a_o,
    output logic [NUM_CH-1:0] port_b_o
);
    logic src_a, src_b;

    assign src_a = cfg_i.seq_mode ? cfg_i.prog[step_idx_i][0] : dir_a_i;
    assign src_b = cfg_i.seq_mode ? cfg_i.prog[step_idx_i][1] : dir_b_i;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit, act_a, act_b;
        assign hit   = sel_valid_i && (chan_i == CH_W'(g));
        assign act_a = hit & src_a;
        assign act_b = hit & src_b;
        assign port_a_o[g] = cfg_i.pol_a ? act_a : ~act_a;
        assign port_b_o[g] = cfg_i.pol_b ? act_b : ~act_b;
    end
endmodule

// File: rtl/rowsw_seq.sv
module rowsw_seq
    import rowsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic              carry_i,
    input  logic              dir_a_i,
    input  logic              dir_b_i,
    input  logic              cfg_shift_i,
    input  logic              cfg_sdi_i,
    input  logic              cfg_load_i,
    output logic              cfg_sdo_o,
    output logic              carry_o,
    output logic              sel_valid_o,
    output logic [CH_W-1:0]   sel_chan_o,
    output logic [NUM_CH-1:0] port_a_o,
    output logic [NUM_CH-1:0] port_b_o
);
    rowsw_cfg_t       cfg;
    logic [SEQ_W-1:0] step_idx;

    rowsw_cfg_chain u_cfg (
        .clk     (clk),
        .rst     (rst),
        .shift_i (cfg_shift_i),
        .sdi_i   (cfg_sdi_i),
        .load_i  (cfg_load_i),
        .sdo_o   (cfg_sdo_o),
        .cfg_o   (cfg)
    );

    rowsw_chan_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cfg_i       (cfg),
        .step_i      (step_i),
        .carry_i     (carry_i),
        .sel_valid_o (sel_valid_o),
        .chan_o      (sel_chan_o),
        .step_idx_o  (step_idx),
        .carry_o     (carry_o)
    );

    rowsw_port_drive u_drv (
        .cfg_i       (cfg),
        .sel_valid_i (sel_valid_o),
        .chan_i      (sel_chan_o),
        .step_idx_i  (step_idx),
        .dir_a_i     (dir_a_i),
        .dir_b_i     (dir_b_i),
        .port_a_o    (port_a_o),
        .port_b_o    (port_b_o)
    );

    assert_one_active_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(port_a_o ^ {NUM_CH{~cfg.pol_a}}) <= 1);

    assert_parked_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !sel_valid_o |-> (port_a_o == {NUM_CH{~cfg.pol_a}} &&
                          port_b_o == {NUM_CH{~cfg.pol_b}}));
endmodule

// File: tb/rowsw_seq_tb_top.sv
`timescale 1ns/1ps
module rowsw_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_i = 1'b0, carry_i = 1'b0, dir_a_i = 1'b0, dir_b_i = 1'b0;
    logic        cfg_shift_i = 1'b0, cfg_sdi_i = 1'b0, cfg_load_i = 1'b0;
    logic        cfg_sdo_o, carry_o, sel_valid_o;
    logic [5:0]  sel_chan_o;
    logic [63:0] port_a_o, port_b_o;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    rowsw_seq dut_i (
        .clk(clk), .rst(rst), .step_i(step_i), .carry_i(carry_i),
        .dir_a_i(dir_a_i), .dir_b_i(dir_b_i), .cfg_shift_i(cfg_shift_i),
        .cfg_sdi_i(cfg_sdi_i), .cfg_load_i(cfg_load_i), .cfg_sdo_o(cfg_sdo_o),
        .carry_o(carry_o), .sel_valid_o(sel_valid_o), .sel_chan_o(sel_chan_o),
        .port_a_o(port_a_o), .port_b_o(port_b_o)
    );

    // {pol_a, pol_b, dir_a, dir_b, exp_a, exp_b}
    localparam logic [5:0] VEC [8] = '{
        6'b1100_00, 6'b1110_10, 6'b1101_01, 6'b1111_11,
        6'b0011_00, 6'b0110_00, 6'b1001_00, 6'b0000_11
    };

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [42:0] mk(logic md, logic pa, logic pb, logic ds,
                                       logic pk, logic [5:0] st, logic [31:0] pr);
        return {pr, st, pk, ds, pb, pa, md};
    endfunction

    // expected port vector: inactive everywhere, channel ch shows level lv when sv
    function automatic logic [63:0] pv(logic pol, logic sv, int ch, logic act);
        logic [63:0] v;
        v = pol ? 64'd0 : ~64'd0;
        if (sv) v[ch] = pol ? act : ~act;
        return v;
    endfunction

    task automatic shift_word(logic [42:0] w);
        for (int i = 0; i < 43; i++) begin
            cfg_sdi_i = w[i];
            cfg_shift_i = 1'b1;
            cyc();
        end
        cfg_shift_i = 1'b0;
    endtask

    task automatic load_word(logic [42:0] w);
        shift_word(w);
        cfg_load_i = 1'b1;
        cyc();
        cfg_load_i = 1'b0;
    endtask

    task automatic pulse_rst();
        rst = 1'b1;
        cyc();
        rst = 1'b0;
        cyc();
    endtask

    task automatic do_step();
        step_i = 1'b1;
        cyc();
        step_i = 1'b0;
        cyc();
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] prog;
        logic [42:0] w1;
        int          bad;

        // R1 reset state with power-up settings
        cyc();
        cyc();
        rst = 1'b0;
        cyc();
        chk("R1 sel_valid", 64'(sel_valid_o), 64'd1);
        chk("R1 chan", 64'(sel_chan_o), 64'd0);
        chk("R1 carry", 64'(carry_o), 64'd0);
        chk("R1 port_a", port_a_o, ~64'd0);
        chk("R1 port_b", port_b_o, ~64'd0);

        // R10 reset goes to the configured start channel
        load_word(mk(0, 1, 1, 0, 0, 6'd20, 32'd0));
        pulse_rst();
        chk("R10 start chan", 64'(sel_chan_o), 64'd20);

        // R4 / R3 direct-mode table
        foreach (VEC[i]) begin
            load_word(mk(0, VEC[i][5], VEC[i][4], 0, 0, 6'd20, 32'd0));
            dir_a_i = VEC[i][3];
            dir_b_i = VEC[i][2];
            #1;
            chk("R4 port_a", port_a_o, pv(VEC[i][5], 1'b1, 20, VEC[i][3]));
            chk("R4 port_b", port_b_o, pv(VEC[i][4], 1'b1, 20, VEC[i][2]));
            chk("R4 sel_a level", 64'(port_a_o[20]), 64'(VEC[i][1]));
            chk("R3 sel_b level", 64'(port_b_o[20]), 64'(VEC[i][0]));
        end

        // R2 stepping
        load_word(mk(0, 1, 1, 0, 0, 6'd20, 32'd0));
        dir_a_i = 1'b1;
        dir_b_i = 1'b0;
        step_i = 1'b1;
        cyc();
        chk("R2 step up", 64'(sel_chan_o), 64'd21);
        chk("R3 port_a one-hot", port_a_o, 64'd1 << 21);
        chk("R3 port_b idle", port_b_o, 64'd0);
        cyc();
        chk("R2 held step", 64'(sel_chan_o), 64'd21);
        step_i = 1'b0;
        cyc();
        do_step();
        chk("R2 second step", 64'(sel_chan_o), 64'd22);

        // R9 load and step in the same cycle: old order applies
        shift_word(mk(0, 1, 1, 1, 0, 6'd20, 32'd0));
        cfg_load_i = 1'b1;
        step_i = 1'b1;
        cyc();
        cfg_load_i = 1'b0;
        step_i = 1'b0;
        chk("R9 same-cycle old order", 64'(sel_chan_o), 64'd23);
        cyc();
        do_step();
        chk("R2 step down", 64'(sel_chan_o), 64'd22);

        // R9 shift without load has no effect
        shift_word(mk(0, 0, 0, 1, 0, 6'd20, 32'd0));
        chk("R9 shift no effect", port_a_o, 64'd1 << 22);
        cfg_load_i = 1'b1;
        cyc();
        cfg_load_i = 1'b0;
        chk("R9 load applies", port_a_o, ~(64'd1 << 22));

        // R10 mid-run reset keeps settings
        pulse_rst();
        chk("R10 chan", 64'(sel_chan_o), 64'd20);
        chk("R10 settings kept", port_a_o, ~(64'd1 << 20));

        // R6 ascending wrap without park
        load_word(mk(0, 1, 1, 0, 0, 6'd62, 32'd0));
        pulse_rst();
        do_step();
        chk("R6 reach 63", 64'(sel_chan_o), 64'd63);
        step_i = 1'b1;
        cyc();
        step_i = 1'b0;
        chk("R6 carry up", 64'(carry_o), 64'd1);
        chk("R6 reload start", 64'(sel_chan_o), 64'd62);
        chk("R6 still selected", 64'(sel_valid_o), 64'd1);
        cyc();
        chk("R6 carry one cycle", 64'(carry_o), 64'd0);

        // R6 descending wrap
        load_word(mk(0, 1, 1, 1, 0, 6'd1, 32'd0));
        pulse_rst();
        do_step();
        chk("R6 reach 0", 64'(sel_chan_o), 64'd0);
        step_i = 1'b1;
        cyc();
        step_i = 1'b0;
        chk("R6 carry down", 64'(carry_o), 64'd1);
        chk("R6 reload start down", 64'(sel_chan_o), 64'd1);
        cyc();

        // R7 park and resume
        load_word(mk(0, 1, 1, 0, 1, 6'd10, 32'd0));
        dir_a_i = 1'b1;
        pulse_rst();
        chk("R7 parked", 64'(sel_valid_o), 64'd0);
        chk("R7 parked ports", port_a_o, 64'd0);
        do_step();
        chk("R7 step ignored", 64'(sel_valid_o), 64'd0);
        carry_i = 1'b1;
        cyc();
        carry_i = 1'b0;
        chk("R7 resume", 64'(sel_valid_o), 64'd1);
        chk("R7 resume chan", 64'(sel_chan_o), 64'd10);
        chk("R7 resume ports", port_a_o, 64'd1 << 10);
        carry_i = 1'b1;
        cyc();
        carry_i = 1'b0;
        cyc();
        chk("R7 carry_i ignored", 64'(sel_chan_o), 64'd10);
        for (int s = 0; s < 53; s++) do_step();
        chk("R6 park reach 63", 64'(sel_chan_o), 64'd63);
        step_i = 1'b1;
        cyc();
        step_i = 1'b0;
        chk("R6 park carry", 64'(carry_o), 64'd1);
        chk("R6 park drop", 64'(sel_valid_o), 64'd0);
        cyc();

        // R5 sequencer mode
        prog = '0;
        for (int k = 0; k < 16; k++) prog[2*k +: 2] = 2'(k % 4);
        load_word(mk(1, 1, 1, 0, 0, 6'd3, prog));
        rst = 1'b1;
        cyc();
        chk("R5 step0 a", port_a_o, 64'd0);
        chk("R5 step0 b", port_b_o, 64'd0);
        rst = 1'b0;
        for (int j = 1; j < 18; j++) begin
            int s;
            s = (j > 15) ? 15 : j;
            cyc();
            chk("R5 prog a", port_a_o, 64'(s % 2) << 3);
            chk("R5 prog b", port_b_o, 64'((s / 2) % 2) << 3);
        end
        step_i = 1'b1;
        cyc();
        step_i = 1'b0;
        chk("R5 restart chan", 64'(sel_chan_o), 64'd4);
        chk("R5 restart a", port_a_o, 64'd0);
        chk("R5 restart b", port_b_o, 64'd0);
        cyc();
        chk("R5 next step", port_a_o, 64'd1 << 4);

        // R8 serial pass-through
        w1 = 43'h5A5_3C3C_96E1;
        shift_word(w1);
        bad = 0;
        for (int i = 0; i < 43; i++) begin
            if (cfg_sdo_o !== w1[i]) bad++;
            cfg_sdi_i = 1'b0;
            cfg_shift_i = 1'b1;
            cyc();
        end
        cfg_shift_i = 1'b0;
        chk("R8 sdo mismatches", 64'(bad), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule